// File: doc/BRIEF.md
# Flash Status Polling Engine

A host-side engine that watches a flash program or erase operation already under way and decides when it has finished and whether it worked. After a start pulse it repeatedly reads the flash status word at a latched address through a simple request/valid read port. It judges every returned word with one of two methods and then reports pass, fail or fail-by-timeout.

In the data-polling method, the engine compares bit 7 of the status word with bit 7 of the data the host expects. An erase is polled with an expected bit 7 of 1. In the toggle method, the engine reads in pairs and checks whether bit 6 has stopped changing. In both methods an error indication on bit 5 does not end the operation at once. The engine first reads the status again, because the operation may have completed in the same moment that the error flag appeared. A read budget ends a run that never settles.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, rd_req_o, done_o, pass_o, fail_o and timeout_o are all 0.
- R2: Each read raises rd_req_o with rd_addr_o equal to the address latched at start. Both stay unchanged until rd_valid_i is seen high. Only the rd_data_i present in that cycle is judged, and the next request comes no earlier than the cycle after.
- R3: With method_i = 0 (data polling), a read whose bit 7 equals bit 7 of the expected data ends the run with pass.
- R4: With method_i = 0, a mismatching bit 7 with bit 5 clear causes another read. A mismatching bit 7 with bit 5 set causes exactly one more read, which gives pass if its bit 7 matches and fail otherwise.
- R5: With method_i = 1 (toggle), reads are taken in pairs. If bit 6 is equal in both reads of a pair, the result is pass. If bit 6 differs and bit 5 of the second read is clear, a new pair starts.
- R6: With method_i = 1, if bit 6 differs within a pair and bit 5 of the second read is set, two further reads are taken. The result is pass if their bit 6 values are equal and fail otherwise.
- R7: If MAX_POLLS reads complete without a result, the run ends with fail_o = 1 and timeout_o = 1. A result reached on read MAX_POLLS itself is reported as that result.
- R8: done_o pulses for exactly one cycle when a run ends. pass_o and fail_o are never both 1. timeout_o = 1 implies fail_o = 1. All three are held until the next accepted start, and they clear in the cycle after it.
- R9: A start_i pulse while a run is in progress is ignored. The address, method, expected data and outcome of the current run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| method_i | input | 1 | 0 = data polling, 1 = toggle |
| addr_i | input | AW | Address to poll |
| exp_data_i | input | DW | Data being written (all ones for erase) |
| rd_req_o | output | 1 | Read request, held until valid |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Status word returned |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run ended with success |
| fail_o | output | 1 | Run ended with failure |
| timeout_o | output | 1 | Failure was caused by the read budget |

## Verification
Data polling is tried with program-style and erase-style expected bit 7 values, with a plain match, and with error-then-match and error-then-mismatch sequences. These separate the recheck path from a first-error abort. Toggle polling is tried with a pair that toggles and then stops, with the error flag followed by a stopped or still-toggling bit 6, and with endless toggling. These distinguish pair restart, the extra two-read confirmation and the budget limit. Read latency varies between runs, and a stray start is pulsed in mid-run, to show that data is judged only at valid and that busy starts are ignored.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int unsigned DQ_POLL = 7;
  localparam int unsigned DQ_TOG  = 6;
  localparam int unsigned DQ_ERR  = 5;

  typedef enum logic [2:0] {
    PH_DP_FIRST,
    PH_DP_RECHK,
    PH_TG_A,
    PH_TG_B,
    PH_TG_C,
    PH_TG_D
  } phase_e;

  typedef enum logic [1:0] {
    V_CONT,
    V_PASS,
    V_FAIL
  } verdict_e;

  typedef struct packed {
    verdict_e verdict;
    phase_e   nxt;
  } judge_t;
endpackage

// File: rtl/poll_rd_port.sv
module poll_rd_port #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  output logic          req_o,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          smp_vld_o,
  output logic [DW-1:0] smp_o
);
  logic          req_q;
  logic          vld_q;
  logic [DW-1:0] smp_q;
  logic          take;

  assign take = req_q && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vld_q <= 1'b0;
      smp_q <= '0;
    end else begin
      vld_q <= take;
      if (take) smp_q <= data_i;
      if (issue_i)   req_q <= 1'b1;
      else if (take) req_q <= 1'b0;
    end
  end

  assign req_o     = req_q;
  assign smp_vld_o = vld_q;
  assign smp_o     = smp_q;

  // R2: request held until accepted
  p_req_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !valid_i |=> req_q);
  // R2: a new read is never issued while one is outstanding or being judged
  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !req_q);
  p_sample_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> !req_q);
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);
  localparam logic [CW-1:0] TOP  = CW'(MAX_POLLS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  p_budget_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import flash_poll_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  phase_e        phase_i,
  input  logic [DW-1:0] smp_i,
  input  logic          prv_tog_i,
  input  logic          exp_poll_i,
  output judge_t        res_o
);
  logic poll_hit, tog_same, err;

  assign poll_hit = (smp_i[DQ_POLL] == exp_poll_i);
  assign tog_same = (smp_i[DQ_TOG] == prv_tog_i);
  assign err      = smp_i[DQ_ERR];

  always_comb begin
    res_o = '{verdict: V_CONT, nxt: phase_i};
    unique case (phase_i)
      PH_DP_FIRST: begin
        if (poll_hit) res_o.verdict = V_PASS;
        else if (err) res_o.nxt = PH_DP_RECHK;
        else          res_o.nxt = PH_DP_FIRST;
      end
      PH_DP_RECHK: res_o.verdict = poll_hit ? V_PASS : V_FAIL;
      PH_TG_A:     res_o.nxt = PH_TG_B;
      PH_TG_B: begin
        if (tog_same) res_o.verdict = V_PASS;
        else if (err) res_o.nxt = PH_TG_C;
        else          res_o.nxt = PH_TG_A;
      end
      PH_TG_C:     res_o.nxt = PH_TG_D;
      PH_TG_D:     res_o.verdict = tog_same ? V_PASS : V_FAIL;
      default:     res_o.verdict = V_FAIL;
    endcase
  end
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int unsigned AW        = 20,
  parameter int unsigned DW        = 16,
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          method_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          timeout_o
);
  logic          busy_q;
  phase_e        phase_q;
  logic [AW-1:0] addr_q;
  logic          exp_q;
  logic          prv_q;
  logic          done_q, pass_q, fail_q, tmo_q;

  logic          start_ok, issue, last, smp_vld;
  logic [DW-1:0] smp;
  judge_t        jr;

  assign start_ok = start_i && !busy_q;
  assign issue    = start_ok || (smp_vld && jr.verdict == V_CONT && !last);

  poll_rd_port #(.DW(DW)) u_port (
    .clk_i, .rst_ni,
    .issue_i   (issue),
    .req_o     (rd_req_o),
    .valid_i   (rd_valid_i),
    .data_i    (rd_data_i),
    .smp_vld_o (smp_vld),
    .smp_o     (smp)
  );

  poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk_i, .rst_ni,
    .clr_i  (start_ok),
    .inc_i  (smp_vld),
    .last_o (last)
  );

  poll_judge #(.DW(DW)) u_judge (
    .phase_i    (phase_q),
    .smp_i      (smp),
    .prv_tog_i  (prv_q),
    .exp_poll_i (exp_q),
    .res_o      (jr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= PH_DP_FIRST;
      addr_q  <= '0;
      exp_q   <= 1'b0;
      prv_q   <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q  <= 1'b1;
        addr_q  <= addr_i;
        exp_q   <= exp_data_i[DQ_POLL];
        phase_q <= method_i ? PH_TG_A : PH_DP_FIRST;
        pass_q  <= 1'b0;
        fail_q  <= 1'b0;
        tmo_q   <= 1'b0;
      end else if (busy_q && smp_vld) begin
        prv_q <= smp[DQ_TOG];
        unique case (jr.verdict)
          V_PASS: begin busy_q <= 1'b0; done_q <= 1'b1; pass_q <= 1'b1; end
          V_FAIL: begin busy_q <= 1'b0; done_q <= 1'b1; fail_q <= 1'b1; end
          default: begin
            if (last) begin
              busy_q <= 1'b0; done_q <= 1'b1; fail_q <= 1'b1; tmo_q <= 1'b1;
            end else begin
              phase_q <= jr.nxt;
            end
          end
        endcase
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;

  p_addr_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> $stable(rd_addr_o));
  p_idle_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !rd_req_o);
  p_busy_start_ign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_q |=> $stable(rd_addr_o));
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_tmo_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> fail_o);
  p_done_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({pass_o, fail_o}) == 1);
endmodule

// File: tb/sim_flash_poll_engine.sv
module sim_flash_poll_engine;
  localparam int AW = 20, DW = 16, MAXP = 10;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic          start = 0, method = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_d = '0;
  logic          rd_req, rd_valid;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          done, pass, fail, tmo;

  flash_poll_engine #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .method_i(method),
    .addr_i(addr), .exp_data_i(exp_d), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .done_o(done), .pass_o(pass),
    .fail_o(fail), .timeout_o(tmo));

  int total = 0, bad = 0;
  bit finished = 0;

  // flash model: scripted status words, programmable latency
  logic [DW-1:0] script [16];
  int            slen = 1, lat = 0, wcnt = 0, idx = 0, reads = 0;
  logic [AW-1:0] cur_addr = '0;
  bit            addr_bad = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0; wcnt <= 0;
    end else begin
      rd_valid <= 1'b0;
      if (rd_req && !rd_valid) begin
        if (wcnt >= lat) begin
          rd_valid <= 1'b1;
          rd_data  <= script[(idx < slen) ? idx : slen - 1];
          idx      <= idx + 1;
          reads    <= reads + 1;
          wcnt     <= 0;
          if (rd_addr != cur_addr) addr_bad <= 1;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  function automatic logic [DW-1:0] word_at(int i);
    return script[(i < slen) ? i : slen - 1];
  endfunction

  // reference: res 0 pass, 1 fail, 2 timeout
  function automatic void ref_model(input bit m, input bit e7,
                                    output int res, output int n);
    int i = 0;
    res = 2;
    n   = MAXP;
    while (i < MAXP) begin
      logic [DW-1:0] a, b;
      a = word_at(i); i++;
      if (!m) begin
        if (a[7] == e7) begin res = 0; n = i; return; end
        if (a[5]) begin
          if (i >= MAXP) return;
          b = word_at(i); i++;
          res = (b[7] == e7) ? 0 : 1; n = i; return;
        end
      end else begin
        if (i >= MAXP) return;
        b = word_at(i); i++;
        if (a[6] == b[6]) begin res = 0; n = i; return; end
        if (b[5]) begin
          if (i + 1 >= MAXP + 1) return;
          a = word_at(i); i++;
          if (i >= MAXP) return;
          b = word_at(i); i++;
          res = (a[6] == b[6]) ? 0 : 1; n = i; return;
        end
      end
    end
  endfunction

  typedef struct { int res; int n; string tag; } exp_t;
  exp_t sb[$];
  int   done_cnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      int   act;
      act = pass ? 0 : (tmo ? 2 : (fail ? 1 : 3));
      if (sb.size() == 0) check(0, "R8", "unexpected done", act, -1);
      else begin
        e = sb.pop_front();
        check(act == e.res, e.tag, "result", act, e.res);
        check(reads == e.n, e.tag, "read count", reads, e.n);
        check(!addr_bad, "R2", "read address", int'(addr_bad), 0);
      end
      done_cnt++;
    end
  end

  task automatic run_op(input bit m, input logic [DW-1:0] e, input logic [AW-1:0] a,
                        input int latency, input string tag, input bit stray);
    exp_t x;
    int   target;
    ref_model(m, e[7], x.res, x.n);
    x.tag = tag;
    sb.push_back(x);
    target = done_cnt + 1;
    @(negedge clk);
    lat = latency; idx = 0; reads = 0; cur_addr = a; addr_bad = 0;
    start = 1; method = m; exp_d = e; addr = a;
    @(negedge clk);
    start = 0;
    check(pass == 0 && fail == 0 && tmo == 0, "R8", "flags cleared at start",
          int'({pass, fail, tmo}), 0);
    if (stray) begin
      repeat (3) @(negedge clk);
      start = 1; method = ~m; exp_d = ~e; addr = ~a;
      @(negedge clk);
      start = 0;
    end
    while (done_cnt < target) @(negedge clk);
    check(done == 0, "R8", "done width", int'(done), 0);
    repeat (3) @(negedge clk);
    check(pass == (x.res == 0) && fail == (x.res != 0), "R8", "result held",
          int'({pass, fail}), (x.res == 0) ? 2 : 1);
    check(rd_req == 0, "R2", "no request after end", int'(rd_req), 0);
  endtask

  task automatic load(input int n, input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                      input logic [DW-1:0] w2, input logic [DW-1:0] w3,
                      input logic [DW-1:0] w4, input logic [DW-1:0] w5);
    script[0] = w0; script[1] = w1; script[2] = w2;
    script[3] = w3; script[4] = w4; script[5] = w5;
    slen = n;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) script[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd_req == 0 && done == 0 && pass == 0 && fail == 0 && tmo == 0,
          "R1", "reset outputs", int'({rd_req, done, pass, fail, tmo}), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 program: busy words show complement of bit 7
    load(3, 16'h0040, 16'h0000, 16'h00A5, 0, 0, 0);
    run_op(0, 16'h00A5, 20'h01234, 0, "R3", 0);
    // R3 erase: expected bit 7 = 1, busy reads 0
    load(4, 16'h0000, 16'h0040, 16'h0000, 16'hFFFF, 0, 0);
    run_op(0, 16'hFFFF, 20'h0A000, 2, "R3", 0);
    // R3 program of a 0 bit
    load(3, 16'h0080, 16'h00C0, 16'h0000, 0, 0, 0);
    run_op(0, 16'h0000, 20'h00010, 1, "R3", 0);
    // R4 error then match on recheck
    load(2, 16'h0020, 16'h0080, 0, 0, 0, 0);
    run_op(0, 16'h0080, 20'h00020, 0, "R4", 0);
    // R4 error then mismatch
    load(2, 16'h0020, 16'h0060, 0, 0, 0, 0);
    run_op(0, 16'h0080, 20'h00030, 3, "R4", 0);
    // R5 toggling pairs then stable
    load(6, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0000);
    run_op(1, 16'h0000, 20'h00040, 0, "R5", 0);
    // R6 error, then bit 6 stopped
    load(4, 16'h0040, 16'h0020, 16'h0000, 16'h0000, 0, 0);
    run_op(1, 16'h0000, 20'h00050, 1, "R6", 0);
    // R6 error, bit 6 still toggling
    load(4, 16'h0040, 16'h0020, 16'h0040, 16'h0000, 0, 0);
    run_op(1, 16'h0000, 20'h00060, 2, "R6", 0);
    // R7 timeout in data polling
    load(1, 16'h0000, 0, 0, 0, 0, 0);
    run_op(0, 16'h0080, 20'h00070, 0, "R7", 0);
    // R7 timeout in toggle mode
    for (int i = 0; i < 16; i++) script[i] = (i % 2 == 0) ? 16'h0040 : 16'h0000;
    slen = 16;
    run_op(1, 16'h0000, 20'h00080, 1, "R7", 0);
    // R9 stray start mid-run
    load(3, 16'h0000, 16'h0000, 16'h0080, 0, 0, 0);
    run_op(0, 16'h0080, 20'h05555, 4, "R9", 1);
    // R7 boundary: result on the final budgeted read
    for (int i = 0; i < 16; i++) script[i] = 16'h0000;
    script[MAXP-1] = 16'h0080; slen = MAXP;
    run_op(0, 16'h0080, 20'h00090, 0, "R7", 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule